// File: doc/BRIEF.md
# Linked Trace Buffer Pool

This block is a small pool of instruction FIFOs placed between several fetch units working in parallel and a single in-order consumer. A fetch unit asks for a buffer and is granted one. It then streams the instructions of one trace into that buffer through its own write port and flags the final instruction as the end of the trace. Several fetch units fill different buffers in the same cycle and in any order.

Each buffer joins the tail of a linked list at the moment it is granted. The list order is therefore the program order of the traces. The single read port always drains the list head. When the head trace ends, it follows the next pointer to the following buffer and frees the drained one. If the head buffer is empty and its trace is still open, the reader waits, even when younger buffers already hold instructions. A flush input empties the whole pool.

Top module: `trace_buf_pool`

## Requirements
- R1: While `alloc_req` is high and `flush` is low, `alloc_gnt` is high in the same cycle if any buffer is free, and `alloc_idx` gives the lowest-numbered free buffer. That buffer becomes busy and joins the tail of the order list at the next clock edge. With all 4 buffers busy, or during `flush`, `alloc_gnt` is low.
- R2: Each buffer holds up to 8 instructions and returns them first in, first out. A write to a buffer that already holds 8 instructions is ignored.
- R3: Write port p uses bits `[p*2 +: 2]` of `wr_idx` and bits `[p*32 +: 32]` of `wr_insn`. Both ports may write different buffers in the same cycle. When both ports are valid for the same buffer, port 0 alone is considered and the write from port 1 is dropped.
- R4: A write to a buffer that is not allocated is ignored. So is a write to a buffer whose trace has already taken an instruction marked end-of-trace.
- R5: `rd_valid` is high when the head buffer holds an instruction. `rd_insn` is then that buffer's oldest instruction. An instruction is consumed on a cycle where `rd_valid` and `rd_ready` are both high. `rd_last` marks the final instruction of a completed trace. Traces come out in grant order.
- R6: While the head buffer is empty and its trace is not complete, `rd_valid` stays low, even if younger buffers hold instructions.
- R7: Consuming the `rd_last` instruction frees its buffer at that clock edge. The freed buffer can be granted from the next cycle on, but not in the same cycle.
- R8: A cycle with `flush` high frees all buffers and discards their contents and the order list. In the following cycle `rd_valid` is low and a request is granted buffer 0.
- R9: After reset `rd_valid` is low, all buffers are free, and a request is granted buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clears every buffer and the order list |
| alloc_req | input | 1 | Request for a new trace buffer |
| alloc_gnt | output | 1 | Request granted this cycle |
| alloc_idx | output | 2 | Index of the granted buffer |
| wr_valid | input | 2 | Per-port write strobe |
| wr_idx | input | 4 | Per-port target buffer, 2 bits per port |
| wr_insn | input | 64 | Per-port instruction, 32 bits per port |
| wr_last | input | 2 | Per-port end-of-trace flag |
| rd_valid | output | 1 | Head buffer offers an instruction |
| rd_ready | input | 1 | Consumer accepts the offered instruction |
| rd_insn | output | 32 | Instruction offered by the head buffer |
| rd_last | output | 1 | Offered instruction ends its trace |

## Verification
The assertions check on every cycle that no buffer is written past its depth or after its trace closed, that no empty buffer is popped, that only busy buffers are released or read, and that a flush leaves the pool idle. Trace ordering, the stall of the head behind younger filled buffers, port 0 priority on a shared target, and the exact moment a freed buffer can be granted again show only in the bench scenarios. There, a reference model of queues and an order list predicts every output, both in directed sequences and under random traffic.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // Index of the lowest zero bit, or 32 when every bit is set.
  function automatic int unsigned lowest_clear(input logic [31:0] vec);
    int unsigned r;
    r = 32;
    for (int i = 31; i >= 0; i--) begin
      if (!vec[i]) r = unsigned'(i);
    end
    return r;
  endfunction

  // Ring pointer advance for a queue of the given depth.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/tbp_fifo.sv
module tbp_fifo
  import tbp_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int INSN_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [INSN_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              rd_en,
  output logic [INSN_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              closed,
  output logic              full,
  output logic              empty
);
  logic [INSN_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      closed <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      closed <= 1'b0;
    end else begin
      if (wr_en) begin
        wr_ptr <= PTR_W'(ring_next(32'(wr_ptr), DEPTH));
        if (wr_last) closed <= 1'b1;
      end
      if (rd_en) rd_ptr <= PTR_W'(ring_next(32'(rd_ptr), DEPTH));
      case ({wr_en, rd_en})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  // R2: the write gate must never let a full buffer grow
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);
  // R4: no write once the trace is closed
  a_r4_closed_no_write: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !closed);
  // R5: the reader never pops an empty buffer
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty);
endmodule

// File: rtl/tbp_alloc.sv
module tbp_alloc
  import tbp_pkg::*;
#(
  parameter int NUM_BUF = 4,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               alloc_req,
  input  logic               release_en,
  input  logic [IDX_W-1:0]   release_idx,
  output logic [NUM_BUF-1:0] busy,
  output logic               gnt,
  output logic [IDX_W-1:0]   idx
);
  logic [31:0]        busy_ext;
  int unsigned        pick;
  logic [NUM_BUF-1:0] set_v, clr_v;

  always_comb begin
    busy_ext = '1;
    busy_ext[NUM_BUF-1:0] = busy;
    pick = lowest_clear(busy_ext);
  end

  assign gnt = alloc_req && !flush && (pick < 32'(NUM_BUF));
  assign idx = IDX_W'(pick);

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (gnt) set_v[idx] = 1'b1;
    if (release_en) clr_v[release_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy <= '0;
    else if (flush) busy <= '0;
    else            busy <= (busy | set_v) & ~clr_v;
  end

  // R7: only a busy buffer can be released by the reader
  a_r7_release_busy: assert property (@(posedge clk) disable iff (!rst_n)
    release_en |-> busy[release_idx]);
endmodule

// File: rtl/tbp_list.sv
module tbp_list #(
  parameter int NUM_BUF = 4,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             append_en,
  input  logic [IDX_W-1:0] append_idx,
  input  logic             retire,
  output logic [IDX_W-1:0] head,
  output logic             nonempty
);
  logic [IDX_W-1:0] tail;
  logic [IDX_W-1:0] next_q [NUM_BUF];
  logic             last_one;

  assign last_one = (head == tail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      nonempty <= 1'b0;
      for (int i = 0; i < NUM_BUF; i++) next_q[i] <= '0;
    end else if (flush) begin
      head     <= '0;
      tail     <= '0;
      nonempty <= 1'b0;
    end else begin
      if (append_en) begin
        tail <= append_idx;
        if (nonempty && !(retire && last_one)) next_q[tail] <= append_idx;
      end
      if (retire) begin
        if (last_one) begin
          if (append_en) head <= append_idx;
          else           nonempty <= 1'b0;
        end else begin
          head <= next_q[head];
        end
      end else if (append_en && !nonempty) begin
        head <= append_idx;
      end
      if (append_en) nonempty <= 1'b1;
    end
  end

  // R5: a trace can only retire from a non-empty list
  a_r5_retire_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> nonempty);
endmodule

// File: rtl/trace_buf_pool.sv
module trace_buf_pool #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 8,
  parameter int NUM_WP  = 2,
  parameter int INSN_W  = 32,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     alloc_req,
  output logic                     alloc_gnt,
  output logic [IDX_W-1:0]         alloc_idx,
  input  logic [NUM_WP-1:0]        wr_valid,
  input  logic [NUM_WP*IDX_W-1:0]  wr_idx,
  input  logic [NUM_WP*INSN_W-1:0] wr_insn,
  input  logic [NUM_WP-1:0]        wr_last,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [INSN_W-1:0]        rd_insn,
  output logic                     rd_last
);
  logic [NUM_BUF-1:0] busy, buf_wr, buf_rd, buf_clr;
  logic [NUM_BUF-1:0] closed, full, empty;
  logic [INSN_W-1:0]  dout  [NUM_BUF];
  logic [CNT_W-1:0]   count [NUM_BUF];
  logic [INSN_W-1:0]  sel_data [NUM_BUF];
  logic [NUM_BUF-1:0] sel_last, sel_hit;
  logic [IDX_W-1:0]   head;
  logic               list_ne, rd_fire, retire;

  tbp_alloc #(.NUM_BUF(NUM_BUF)) u_alloc (
    .clk, .rst_n, .flush, .alloc_req,
    .release_en(retire), .release_idx(head),
    .busy, .gnt(alloc_gnt), .idx(alloc_idx)
  );

  tbp_list #(.NUM_BUF(NUM_BUF)) u_list (
    .clk, .rst_n, .flush,
    .append_en(alloc_gnt), .append_idx(alloc_idx),
    .retire, .head, .nonempty(list_ne)
  );

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    // Lower port numbers win when several ports aim at this buffer.
    always_comb begin
      sel_hit[b]  = 1'b0;
      sel_data[b] = '0;
      sel_last[b] = 1'b0;
      for (int p = NUM_WP - 1; p >= 0; p--) begin
        if (wr_valid[p] && wr_idx[p*IDX_W +: IDX_W] == IDX_W'(b)) begin
          sel_hit[b]  = 1'b1;
          sel_data[b] = wr_insn[p*INSN_W +: INSN_W];
          sel_last[b] = wr_last[p];
        end
      end
    end

    assign buf_wr[b]  = sel_hit[b] && busy[b] && !closed[b] && !full[b] && !flush;
    assign buf_rd[b]  = rd_fire && (head == IDX_W'(b));
    assign buf_clr[b] = alloc_gnt && (alloc_idx == IDX_W'(b));

    tbp_fifo #(.DEPTH(DEPTH), .INSN_W(INSN_W)) u_fifo (
      .clk, .rst_n, .clr(buf_clr[b]),
      .wr_en(buf_wr[b]), .wr_data(sel_data[b]), .wr_last(sel_last[b]),
      .rd_en(buf_rd[b]), .rd_data(dout[b]), .count(count[b]),
      .closed(closed[b]), .full(full[b]), .empty(empty[b])
    );
  end

  assign rd_valid = list_ne && !empty[head];
  assign rd_insn  = dout[head];
  assign rd_last  = closed[head] && (count[head] == CNT_W'(1));
  assign rd_fire  = rd_valid && rd_ready && !flush;
  assign retire   = rd_fire && rd_last;

  // R5: the head of the order list is always an allocated buffer
  a_r5_head_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy[head]);
  // R8: a flush leaves the pool empty and idle
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (!rd_valid && busy == '0));
endmodule

// File: tb/trace_buf_pool_bench.sv
module trace_buf_pool_bench;
  typedef bit [31:0] q_t [$];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_flush = 1'b0, s_areq = 1'b0, s_rr = 1'b0;
  logic [1:0]  s_wv = '0, s_wl = '0;
  logic [1:0]  s_widx [2];
  logic [31:0] s_wd [2];
  logic        alloc_gnt, rd_valid, rd_last;
  logic [1:0]  alloc_idx;
  logic [31:0] rd_insn;

  int checks = 0;
  int failures = 0;

  q_t  mq [4];
  bit  mbusy [4];
  bit  mdone [4];
  int  morder [$];

  always #10 clk = ~clk;

  trace_buf_pool u_trace_buf_pool (
    .clk, .rst_n, .flush(s_flush), .alloc_req(s_areq),
    .alloc_gnt, .alloc_idx,
    .wr_valid(s_wv), .wr_idx({s_widx[1], s_widx[0]}),
    .wr_insn({s_wd[1], s_wd[0]}), .wr_last(s_wl),
    .rd_valid, .rd_ready(s_rr), .rd_insn, .rd_last
  );

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 4; i++) begin
      mq[i].delete();
      mbusy[i] = 1'b0;
      mdone[i] = 1'b0;
    end
    morder.delete();
  endfunction

  function automatic bit can_take(int i, bit valid);
    return valid && mbusy[i] && !mdone[i] && mq[i].size() < 8 && !s_flush;
  endfunction

  task automatic idle();
    s_flush = 0; s_areq = 0; s_rr = 0; s_wv = '0; s_wl = '0;
    s_widx[0] = '0; s_widx[1] = '0; s_wd[0] = '0; s_wd[1] = '0;
  endtask

  task automatic put(int p, int b, logic [31:0] d, bit l);
    s_wv[p] = 1'b1; s_widx[p] = 2'(b); s_wd[p] = d; s_wl[p] = l;
  endtask

  // One clock: check outputs against the model, then advance the model.
  task automatic cyc(input string tag);
    bit eg, ev, el, a0, a1, fire;
    int ei, h, i0, i1;
    string rt;
    #1;
    eg = 0; ei = 0;
    for (int i = 3; i >= 0; i--) if (!mbusy[i]) begin eg = 1; ei = i; end
    eg = eg && s_areq && !s_flush;
    ev = morder.size() > 0 && mq[morder[0]].size() > 0;
    h  = (morder.size() > 0) ? morder[0] : 0;
    el = ev && mdone[h] && mq[h].size() == 1;
    rt = tag;
    if (rt == "") rt = (morder.size() > 0 && !ev) ? "R6" : "R5";
    chk(alloc_gnt === eg, (tag == "") ? "R1" : tag, 32'(alloc_gnt), 32'(eg));
    if (eg) chk(alloc_idx === 2'(ei), (tag == "") ? "R1" : tag, 32'(alloc_idx), 32'(ei));
    chk(rd_valid === ev, rt, 32'(rd_valid), 32'(ev));
    if (ev) begin
      chk(rd_insn === mq[h][0], rt, rd_insn, mq[h][0]);
      chk(rd_last === el, (tag == "") ? "R5" : tag, 32'(rd_last), 32'(el));
    end
    i0 = int'(s_widx[0]);
    i1 = int'(s_widx[1]);
    a0 = can_take(i0, s_wv[0]);
    a1 = can_take(i1, s_wv[1] && !(s_wv[0] && i0 == i1));
    fire = ev && s_rr && !s_flush;
    @(posedge clk);
    if (s_flush) model_clear();
    else begin
      if (a0) begin mq[i0].push_back(s_wd[0]); if (s_wl[0]) mdone[i0] = 1; end
      if (a1) begin mq[i1].push_back(s_wd[1]); if (s_wl[1]) mdone[i1] = 1; end
      if (fire) begin
        void'(mq[h].pop_front());
        if (el) begin mbusy[h] = 0; void'(morder.pop_front()); end
      end
      if (eg) begin
        mbusy[ei] = 1; mdone[ei] = 0; mq[ei].delete(); morder.push_back(ei);
      end
    end
    @(negedge clk);
  endtask

  task automatic do_flush();
    idle(); s_flush = 1; cyc(""); idle();
  endtask

  task automatic grab(int n, string tag);
    for (int i = 0; i < n; i++) begin idle(); s_areq = 1; cyc(tag); end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    s_areq = 1; #1;
    chk(rd_valid === 1'b0, "R9", 32'(rd_valid), 0);
    chk(alloc_gnt === 1'b1, "R9", 32'(alloc_gnt), 1);
    chk(alloc_idx === 2'd0, "R9", 32'(alloc_idx), 0);
    cyc("R9");
    idle();

    // R1: fill all four, the fifth request is refused
    grab(3, "R1");
    s_areq = 1; cyc("R1"); idle();

    // R3: shared target, then two buffers in parallel
    do_flush(); grab(2, "R3");
    put(0, 0, 32'hA000_0000, 0); put(1, 0, 32'hB000_0000, 0); cyc("R3"); idle();
    put(0, 1, 32'hC100_0000, 1); put(1, 0, 32'hD000_0000, 1); cyc("R3"); idle();
    s_rr = 1; repeat (4) cyc("R3"); idle();

    // R2: nine writes into a depth-8 buffer, drain one, close, read out
    do_flush(); grab(1, "R2");
    for (int k = 0; k < 9; k++) begin put(0, 0, 32'h2000_0000 + k, 0); cyc("R2"); end
    idle(); s_rr = 1; cyc("R2"); idle();
    put(1, 0, 32'h2FFF_0000, 1); cyc("R2"); idle();
    s_rr = 1; repeat (9) cyc("R2"); idle();

    // R4: writes after end-of-trace and to a free buffer are dropped
    do_flush(); grab(1, "R4");
    put(0, 0, 32'h4000_0001, 1); cyc("R4"); idle();
    put(0, 0, 32'h4000_0002, 0); put(1, 3, 32'h4000_0003, 1); cyc("R4"); idle();
    s_rr = 1; repeat (3) cyc("R4"); idle();
    s_areq = 1; cyc("R4"); idle();
    s_rr = 1; repeat (2) cyc("R4"); idle();

    // R6: younger buffer full of data, oldest still open
    do_flush(); grab(2, "R6");
    put(0, 1, 32'h6100_0000, 0); cyc("R6"); idle();
    put(1, 1, 32'h6100_0001, 1); s_rr = 1; cyc("R6"); idle();
    s_rr = 1; repeat (2) cyc("R6"); idle();
    put(0, 0, 32'h6000_0000, 1); cyc("R5"); idle();
    s_rr = 1; repeat (5) cyc("R5"); idle();

    // R7: freed buffer granted only from the next cycle
    do_flush(); grab(4, "R1");
    s_areq = 1; cyc("R1"); idle();
    put(0, 0, 32'h7000_0000, 1); cyc("R7"); idle();
    s_rr = 1; s_areq = 1; cyc("R7"); idle();
    s_areq = 1; cyc("R7"); idle();

    // R8: flush with traffic pending
    put(0, 1, 32'h8000_0000, 1); cyc("R8"); idle();
    s_flush = 1; s_areq = 1; s_rr = 1; put(0, 2, 32'h8000_0001, 0); cyc("R8"); idle();
    s_areq = 1; cyc("R8"); idle();
    s_rr = 1; cyc("R8"); idle();

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      s_flush = ($urandom % 300) == 0;
      s_areq  = ($urandom % 4) == 0;
      s_rr    = ($urandom % 4) != 0;
      for (int p = 0; p < 2; p++) begin
        s_wv[p] = ($urandom % 3) != 0;
        if (morder.size() > 0 && ($urandom % 5) != 0)
          s_widx[p] = 2'(morder[$urandom % morder.size()]);
        else
          s_widx[p] = 2'($urandom % 4);
        s_wd[p] = $urandom;
        s_wl[p] = ($urandom % 7) == 0;
      end
      cyc("");
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule